// File: doc/BRIEF.md
# Configurable UART Transmit Framer

This block turns one character at a time into an asynchronous serial frame on a single output line. A character arrives through a valid/ready handshake. The block accepts it only when every start condition holds, then shifts out a low start bit, 5 to 8 data bits, an optional parity bit and one or two high stop bits. Each bit lasts a fixed number of strobes of an oversampling baud tick, which is 16 by default.

The frame format comes from static line-control inputs. These select the word length, whether parity is on, even or odd parity, stick (constant) parity, and two stop bits. The format is captured together with the character, so a change during a frame takes effect on the next one.

Three controls stop new frames from starting, but none of them cuts a frame short:

- the two enables (whole UART and transmitter);
- a clear-to-send input, when its flow-control enable is set;
- a send-break control, which forces the idle line low.

Top module: `uart_tx_framer`

## Requirements
- R1: A frame is a low start bit, then the data bits, then the parity bit (only when parity is enabled), then a high stop bit. When the two-stop select is 1, a second high stop bit follows. The whole frame format and the data are taken from the inputs in the cycle of the handshake.
- R2: The word-length code selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent least-significant bit first. Data bits above the selected length are not sent.
- R3: With parity enabled and stick parity off, even-select 0 gives odd parity: the total number of ones in the sent data bits plus the parity bit is odd. Even-select 1 gives even parity.
- R4: With parity enabled and stick parity on, the parity bit is a constant 1 when even-select is 0 and a constant 0 when even-select is 1.
- R5: Every bit lasts exactly OSR tick strobes. The busy output goes high in the cycle after the handshake and stays high until the last stop bit has ended. Busy falls only in a cycle that follows a tick.
- R6: While send-break is 1 and no frame is in progress, the line is driven low and no character is accepted. Raising send-break during a frame does not change that frame.
- R7: A character is accepted only while both the UART enable and the transmit enable are 1. Clearing either enable during a frame lets the frame finish unchanged.
- R8: With flow control enabled, a character is accepted only while clear-to-send is 1. Dropping clear-to-send during a frame does not cut it short. With flow control disabled, clear-to-send has no effect.
- R9: After reset the line is high, busy is low, and the line stays high while idle without a break.
- R10: in_ready is high only when no frame is in progress and all start conditions hold. Changes to the data and the line-control inputs after the handshake do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling baud strobe, one clock wide |
| in_valid | input | 1 | A character is offered |
| in_data | input | 8 | Character; the low bits are used for short words |
| in_ready | output | 1 | The character is taken in this cycle when in_valid is also high |
| uart_en | input | 1 | Whole-UART enable |
| tx_en | input | 1 | Transmitter enable |
| cts | input | 1 | Clear-to-send, active high |
| cts_flow_en | input | 1 | Makes starts depend on cts |
| wlen | input | 2 | Word-length code |
| par_en | input | 1 | Parity bit present |
| even_sel | input | 1 | 1 selects even parity, 0 selects odd parity |
| stick_par | input | 1 | Constant parity bit |
| two_stop | input | 1 | Send two stop bits |
| send_break | input | 1 | Hold the line low when idle |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |

## Verification
in_ready depends combinationally on the current inputs and the idle state, so it is checked in the same cycle as the inputs that produce it. The start bit and busy both appear in the first cycle after the handshake edge. Each later bit boundary occurs one clock after the OSR-th tick of the previous bit.

The bench model advances on every rising edge from the inputs that were applied at the preceding falling edge. It compares txd, busy and in_ready a few nanoseconds after that edge, before any input changes. As a result, both sides are judged on the same edge and the same stimulus.

The break level is the one combinational path from an input to txd, so it is due in the same cycle as send_break.

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       uart_en,
  input  logic       tx_en,
  input  logic       cts,
  input  logic       cts_flow_en,
  input  logic [1:0] wlen,
  input  logic       par_en,
  input  logic       even_sel,
  input  logic       stick_par,
  input  logic       two_stop,
  input  logic       send_break,
  output logic       txd,
  output logic       busy
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] SUB_LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2
  } st_t;

  st_t           st;
  logic [CW-1:0] sub;
  logic [2:0]    bidx;
  logic [2:0]    last_idx;
  logic [7:0]    shr;
  logic          par_on, par_val, stop2;

  logic       can_start, accept, bit_end;
  logic [7:0] mask;
  logic       ones_odd, par_next;

  assign can_start = uart_en && tx_en && !send_break && (!cts_flow_en || cts);
  assign in_ready  = (st == S_IDLE) && can_start;
  assign accept    = in_valid && in_ready;
  assign bit_end   = tick && (sub == SUB_LAST);
  assign busy      = (st != S_IDLE);

  always_comb begin
    case (wlen)
      2'b00:   mask = 8'h1F;
      2'b01:   mask = 8'h3F;
      2'b10:   mask = 8'h7F;
      default: mask = 8'hFF;
    endcase
  end

  assign ones_odd = ^(in_data & mask);
  assign par_next = stick_par ? ~even_sel : (even_sel ? ones_odd : ~ones_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sub      <= '0;
      bidx     <= '0;
      last_idx <= 3'd7;
      shr      <= '0;
      par_on   <= 1'b0;
      par_val  <= 1'b0;
      stop2    <= 1'b0;
    end else if (st == S_IDLE) begin
      if (accept) begin
        st       <= S_START;
        sub      <= '0;
        bidx     <= '0;
        last_idx <= {1'b1, wlen};
        shr      <= in_data & mask;
        par_on   <= par_en;
        par_val  <= par_next;
        stop2    <= two_stop;
      end
    end else if (tick) begin
      if (!bit_end) begin
        sub <= sub + 1'b1;
      end else begin
        sub <= '0;
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            shr <= {1'b0, shr[7:1]};
            if (bidx == last_idx) st <= par_on ? S_PAR : S_STOP1;
            else bidx <= bidx + 1'b1;
          end
          S_PAR:   st <= S_STOP1;
          S_STOP1: st <= stop2 ? S_STOP2 : S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      S_IDLE:  txd = ~send_break;
      S_START: txd = 1'b0;
      S_DATA:  txd = shr[0];
      S_PAR:   txd = par_val;
      default: txd = 1'b1;
    endcase
  end
endmodule

module uart_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_ready,
  input logic uart_en,
  input logic tx_en,
  input logic cts,
  input logic cts_flow_en,
  input logic send_break,
  input logic txd,
  input logic busy
);
  a_r9_reset_idle: assert property (@(posedge clk) !rst_n |=> !busy);
  a_r5_busy_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);
  a_r10_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !busy);
  a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !(uart_en && tx_en) |-> !in_ready);
  a_r8_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_flow_en && !cts) |-> !in_ready);
  a_r6_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (send_break && !busy) |-> !txd);
  a_r6_break_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    send_break |-> !in_ready);
  a_r1_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);
endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .in_ready(in_ready),
  .uart_en(uart_en), .tx_en(tx_en), .cts(cts), .cts_flow_en(cts_flow_en),
  .send_break(send_break), .txd(txd), .busy(busy)
);

// File: tb/uart_tx_framer_tb.sv
module uart_tx_framer_tb;
  localparam int OSR = 16;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic uart_en = 1'b1, tx_en = 1'b1, cts = 1'b1, cts_flow_en = 1'b0;
  logic [1:0] wlen = 2'b11;
  logic par_en = 1'b0, even_sel = 1'b0, stick_par = 1'b0, two_stop = 1'b0, send_break = 1'b0;
  logic in_ready, txd, busy;

  uart_tx_framer #(.OSR(OSR)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .uart_en(uart_en), .tx_en(tx_en), .cts(cts),
    .cts_flow_en(cts_flow_en), .wlen(wlen), .par_en(par_en), .even_sel(even_sel),
    .stick_par(stick_par), .two_stop(two_stop), .send_break(send_break),
    .txd(txd), .busy(busy)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0, acc_cnt = 0;
  bit m_busy = 0;
  int m_pos = 0, m_sub = 0, m_len = 0;
  bit m_frame [12];
  int m_kind [12];
  bit done = 0;

  function automatic string kind_tag(int k);
    case (k)
      0: return "R1 start";
      1: return "R2 data";
      2: return "R3 parity";
      3: return "R4 stick parity";
      default: return "R1 stop";
    endcase
  endfunction

  function automatic bit start_ok();
    return uart_en && tx_en && !send_break && (!cts_flow_en || cts);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    tick <= ~tick;
  end

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_pos = 0; m_sub = 0;
    end else if (!m_busy) begin
      if (in_valid && start_ok()) begin
        int n, ones;
        n = 5 + int'(wlen);
        ones = 0;
        m_frame[0] = 1'b0; m_kind[0] = 0;
        for (int i = 0; i < n; i++) begin
          m_frame[1+i] = in_data[i]; m_kind[1+i] = 1;
          ones += int'(in_data[i]);
        end
        m_len = 1 + n;
        if (par_en) begin
          if (stick_par) begin
            m_frame[m_len] = ~even_sel; m_kind[m_len] = 3;
          end else begin
            m_frame[m_len] = even_sel ? (ones % 2 == 1) : (ones % 2 == 0);
            m_kind[m_len] = 2;
          end
          m_len++;
        end
        m_frame[m_len] = 1'b1; m_kind[m_len] = 4; m_len++;
        if (two_stop) begin
          m_frame[m_len] = 1'b1; m_kind[m_len] = 4; m_len++;
        end
        m_busy = 1; m_pos = 0; m_sub = 0;
        acc_cnt++;
      end
    end else if (tick) begin
      m_sub++;
      if (m_sub == OSR) begin
        m_sub = 0;
        m_pos++;
        if (m_pos == m_len) m_busy = 0;
      end
    end
    #4;
    if (rst_n && !done) begin
      bit ex_txd, ex_rdy;
      ex_txd = m_busy ? m_frame[m_pos] : ~send_break;
      ex_rdy = !m_busy && start_ok();
      check(txd === ex_txd, m_busy ? kind_tag(m_kind[m_pos]) : (send_break ? "R6 break" : "R9 idle"),
            int'(txd), int'(ex_txd));
      check(busy === m_busy, "R5 busy", int'(busy), int'(m_busy));
      check(in_ready === ex_rdy,
            !(uart_en && tx_en) ? "R7 ready" : (cts_flow_en && !cts) ? "R8 ready" :
            send_break ? "R6 ready" : "R10 ready", int'(in_ready), int'(ex_rdy));
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cycles);
      summary();
    end
  end

  task automatic set_fmt(input [1:0] w, input bit pe, input bit es, input bit sp, input bit ts);
    wlen = w; par_en = pe; even_sel = es; stick_par = sp; two_stop = ts;
  endtask

  task automatic offer(input [7:0] d);
    int a;
    a = acc_cnt;
    in_data = d; in_valid = 1'b1;
    while (acc_cnt == a) @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input [7:0] d);
    offer(d);
    wait_idle();
  endtask

  task automatic hold_blocked(input int n, input string tag);
    int a;
    a = acc_cnt;
    in_data = 8'h3C; in_valid = 1'b1;
    repeat (n) @(negedge clk);
    in_valid = 1'b0;
    check(acc_cnt == a, tag, acc_cnt - a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R9 reset txd", int'(txd), 1);
    check(busy === 1'b0, "R9 reset busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    set_fmt(2'b11, 0, 0, 0, 0); send(8'hA5);
    set_fmt(2'b00, 1, 0, 0, 0); send(8'hFF);
    set_fmt(2'b01, 1, 1, 0, 0); send(8'hD3);
    set_fmt(2'b10, 1, 0, 0, 0); send(8'h6A);
    set_fmt(2'b11, 1, 1, 0, 0); send(8'h81);
    set_fmt(2'b11, 1, 0, 1, 0); send(8'h00);
    set_fmt(2'b11, 1, 1, 1, 0); send(8'hFF);
    set_fmt(2'b00, 0, 0, 0, 1); send(8'h15);
    set_fmt(2'b11, 1, 1, 0, 1); send(8'h5A);

    set_fmt(2'b11, 0, 0, 0, 0);
    offer(8'h96);
    in_data = 8'h00; wlen = 2'b00; two_stop = 1'b1; par_en = 1'b1;
    wait_idle();
    set_fmt(2'b11, 0, 0, 0, 0);

    offer(8'hC3);
    repeat (60) @(negedge clk);
    send_break = 1'b1;
    wait_idle();
    hold_blocked(80, "R6 no accept in break");
    send_break = 1'b0;
    repeat (4) @(negedge clk);

    offer(8'h71);
    repeat (40) @(negedge clk);
    tx_en = 1'b0;
    wait_idle();
    hold_blocked(60, "R7 tx disabled");
    tx_en = 1'b1;
    offer(8'h0F);
    repeat (100) @(negedge clk);
    uart_en = 1'b0;
    wait_idle();
    hold_blocked(60, "R7 uart disabled");
    uart_en = 1'b1;

    cts_flow_en = 1'b1; cts = 1'b0;
    hold_blocked(60, "R8 cts low blocks");
    cts = 1'b1;
    offer(8'hE4);
    repeat (50) @(negedge clk);
    cts = 1'b0;
    wait_idle();
    cts_flow_en = 1'b0;
    send(8'h2B);
    cts = 1'b1;

    done = 1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule